// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block runs the refill of one cache line after a miss. It fetches the line from a memory port that moves one word at a time. It takes a miss request made of a line address and a word offset. It then issues one request per word to memory and writes each returning word into the data array through a line write port. As soon as the word that missed comes back, the block hands that word to the processor, and the processor may resume. The rest of the line keeps arriving in the background.

Two fetch orders are supported, selected by `order_crit` when the miss is accepted. In wrap order (`order_crit` = 1), the first request is for the missed word. The requests then climb through the line and wrap past the last word to word 0. In natural order (`order_crit` = 0), the requests start at word 0 and climb. The processor is released when the missed word arrives, which may be mid-line. The block serves at most one refill at a time. While a refill is running, the processor can probe the line being filled. Words already written are returned from the block's own fill buffer. Words not yet written report a stall.

Stream rules. A miss is taken on a cycle where `miss_valid` and `miss_ready` are both high. `miss_ready` is high only when no refill is in progress. A memory request moves on a cycle where `mem_req_valid` and `mem_req_ready` are both high. While `mem_req_ready` is low, the block holds the request and its address unchanged. A memory beat moves on a cycle where `mem_beat_valid` and `mem_beat_ready` are both high. `mem_beat_ready` is high only while at least one accepted request still awaits its beat. Memory must return beats in the order it accepted the requests. Memory may insert idle cycles between requests or between beats.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1, and `mem_req_valid`, `fill_we`, `cpu_data_valid` and `line_valid` are all 0.
- R2: With `order_crit` = 1 and miss offset o, the eight requests carry the offsets (o+k) mod 8 for k = 0..7, in that order, each with the miss line address.
- R3: With `order_crit` = 0, the eight requests carry the offsets 0,1,...,7 in that order, whatever the miss offset.
- R4: `cpu_data_valid` is 1 for exactly one cycle per refill. That cycle is the one in which the beat for the missed word is accepted, and `cpu_data` equals that beat's data.
- R5: Every accepted beat raises `fill_we` in the same cycle. `fill_word` equals the offset of the matching request, `fill_data` equals the beat data, and `fill_line` equals the miss line.
- R6: `line_valid` pulses for one cycle, in the cycle after the eighth word is written, and at no other time during the refill.
- R7: `miss_ready` is 0 from the cycle after a miss is accepted until the cycle after `line_valid`. A second miss held on the input is therefore accepted exactly one cycle after `line_valid`.
- R8: Exactly eight requests are issued per refill. While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and its offset stays unchanged in the next cycle.
- R9: While a refill is running, a probe with `cpu_rd_valid` = 1 behaves as follows. If it names the line being filled and a word written in an earlier cycle, it gives `cpu_rd_hit` = 1 with that word's data. If it names an unwritten word of that line, it gives `cpu_rd_stall` = 1. If it names any other line, both outputs are 0.
- R10: `order_crit` is sampled only when a miss is accepted. Changing it during a refill has no effect on that refill's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| order_crit | input | 1 | 1 = wrap order from the missed word, 0 = natural order |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Block idle, miss can be taken |
| miss_line | input | LINE_A_W | Line address of the miss |
| miss_off | input | OFF_W | Word offset of the missed word |
| mem_req_valid | output | 1 | Word request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_line | output | LINE_A_W | Line address of the request |
| mem_req_off | output | OFF_W | Word offset of the request |
| mem_beat_valid | input | 1 | Returning word valid |
| mem_beat_ready | output | 1 | Block can take a returning word |
| mem_beat_data | input | WORD_W | Returning word |
| fill_we | output | 1 | Data array write strobe |
| fill_line | output | LINE_A_W | Line address being written |
| fill_word | output | OFF_W | Word offset being written |
| fill_data | output | WORD_W | Word being written |
| line_valid | output | 1 | Pulse: line complete, its valid bit may be set |
| cpu_data_valid | output | 1 | Missed word delivered, processor may resume |
| cpu_data | output | WORD_W | Missed word |
| cpu_rd_valid | input | 1 | Processor probe of the line in fill |
| cpu_rd_line | input | LINE_A_W | Probe line address |
| cpu_rd_off | input | OFF_W | Probe word offset |
| cpu_rd_hit | output | 1 | Probe served from the fill buffer |
| cpu_rd_stall | output | 1 | Probe must wait, word not yet written |
| cpu_rd_data | output | WORD_W | Probe data when hit |

## Verification
Refills are run with miss offsets 0, 5 and 7 in wrap order. Offset 0 shows that wrapping does not disturb the plain order. Offset 5 separates the wrap from a natural sweep. Offset 7 forces the wrap on the second request. Natural order is run with offsets 5 and 0, which shows that the release follows the missed word rather than the first beat. Some runs add request back-pressure and gaps between beats, to expose any release or seal tied to cycle counts instead of handshakes. Further runs cover a mode flip during a refill, a second miss held waiting, and probes of written words, unwritten words and a foreign line during a fill.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_FILL = 2'd1,
    FS_SEAL = 2'd2
  } fill_state_e;
endpackage

// File: rtl/cwf_wrap_idx.sv
// Maps a beat count to a word offset, starting from a base offset and
// wrapping modulo the (power-of-two) line length.
module cwf_wrap_idx #(
  parameter int OFF_W = 3
) (
  input  logic [OFF_W-1:0] base,
  input  logic [OFF_W-1:0] step,
  output logic [OFF_W-1:0] idx
);
  assign idx = base + step;
endmodule

// File: rtl/cwf_fill_buf.sv
// Per-word holding registers with a written mask for reads during a fill.
module cwf_fill_buf #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  we,
  input  logic [OFF_W-1:0]      widx,
  input  logic [WORD_W-1:0]     wdata,
  input  logic [OFF_W-1:0]      ridx,
  output logic [WORD_W-1:0]     rdata,
  output logic [LINE_WORDS-1:0] written
);
  logic [WORD_W-1:0] word_q [LINE_WORDS];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        written[w] <= 1'b0;
      end else if (we && widx == OFF_W'(w)) begin
        written[w] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (we && widx == OFF_W'(w)) begin
        word_q[w] <= wdata;
      end
    end
  end

  assign rdata = word_q[ridx];
endmodule

// File: rtl/cwf_seq.sv
// Refill sequencer: captures the miss, counts requests and beats, seals.
module cwf_seq
  import cwf_pkg::*;
#(
  parameter int LINE_A_W   = 27,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                miss_valid,
  input  logic [LINE_A_W-1:0] miss_line,
  input  logic [OFF_W-1:0]    miss_off,
  input  logic                order_crit,
  input  logic                req_fire,
  input  logic                beat_fire,
  output logic                idle,
  output logic                filling,
  output logic                req_open,
  output logic                beat_open,
  output logic                seal,
  output logic [LINE_A_W-1:0] line_q,
  output logic [OFF_W-1:0]    crit_q,
  output logic [OFF_W-1:0]    base_q,
  output logic [OFF_W-1:0]    req_step,
  output logic [OFF_W-1:0]    beat_step
);
  localparam logic [OFF_W:0] FULL = (OFF_W+1)'(LINE_WORDS);
  localparam logic [OFF_W:0] LAST = (OFF_W+1)'(LINE_WORDS - 1);

  fill_state_e     state_q;
  logic [OFF_W:0]  req_cnt_q;
  logic [OFF_W:0]  beat_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= FS_IDLE;
      line_q     <= '0;
      crit_q     <= '0;
      base_q     <= '0;
      req_cnt_q  <= '0;
      beat_cnt_q <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: begin
          if (miss_valid) begin
            state_q    <= FS_FILL;
            line_q     <= miss_line;
            crit_q     <= miss_off;
            base_q     <= order_crit ? miss_off : '0;
            req_cnt_q  <= '0;
            beat_cnt_q <= '0;
          end
        end
        FS_FILL: begin
          if (req_fire) req_cnt_q <= req_cnt_q + 1'b1;
          if (beat_fire) begin
            beat_cnt_q <= beat_cnt_q + 1'b1;
            if (beat_cnt_q == LAST) state_q <= FS_SEAL;
          end
        end
        FS_SEAL: state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == FS_IDLE);
  assign filling   = (state_q != FS_IDLE);
  assign seal      = (state_q == FS_SEAL);
  assign req_open  = (state_q == FS_FILL) && (req_cnt_q < FULL);
  assign beat_open = (state_q == FS_FILL) && (beat_cnt_q < req_cnt_q);
  assign req_step  = req_cnt_q[OFF_W-1:0];
  assign beat_step = beat_cnt_q[OFF_W-1:0];
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl #(
  parameter int LINE_A_W   = 27,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                order_crit,
  input  logic                miss_valid,
  output logic                miss_ready,
  input  logic [LINE_A_W-1:0] miss_line,
  input  logic [OFF_W-1:0]    miss_off,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [LINE_A_W-1:0] mem_req_line,
  output logic [OFF_W-1:0]    mem_req_off,
  input  logic                mem_beat_valid,
  output logic                mem_beat_ready,
  input  logic [WORD_W-1:0]   mem_beat_data,
  output logic                fill_we,
  output logic [LINE_A_W-1:0] fill_line,
  output logic [OFF_W-1:0]    fill_word,
  output logic [WORD_W-1:0]   fill_data,
  output logic                line_valid,
  output logic                cpu_data_valid,
  output logic [WORD_W-1:0]   cpu_data,
  input  logic                cpu_rd_valid,
  input  logic [LINE_A_W-1:0] cpu_rd_line,
  input  logic [OFF_W-1:0]    cpu_rd_off,
  output logic                cpu_rd_hit,
  output logic                cpu_rd_stall,
  output logic [WORD_W-1:0]   cpu_rd_data
);
  logic                  idle, filling, req_open, beat_open, seal;
  logic [LINE_A_W-1:0]   line_q;
  logic [OFF_W-1:0]      crit_q, base_q, req_step, beat_step;
  logic [OFF_W-1:0]      req_idx, beat_idx;
  logic [LINE_WORDS-1:0] written;
  logic                  req_fire, beat_fire, take_miss, probe_match;

  assign req_fire  = mem_req_valid && mem_req_ready;
  assign beat_fire = mem_beat_valid && mem_beat_ready;
  assign take_miss = miss_valid && idle;

  cwf_seq #(
    .LINE_A_W  (LINE_A_W),
    .LINE_WORDS(LINE_WORDS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .miss_valid(miss_valid),
    .miss_line (miss_line),
    .miss_off  (miss_off),
    .order_crit(order_crit),
    .req_fire  (req_fire),
    .beat_fire (beat_fire),
    .idle      (idle),
    .filling   (filling),
    .req_open  (req_open),
    .beat_open (beat_open),
    .seal      (seal),
    .line_q    (line_q),
    .crit_q    (crit_q),
    .base_q    (base_q),
    .req_step  (req_step),
    .beat_step (beat_step)
  );

  cwf_wrap_idx #(.OFF_W(OFF_W)) u_req_idx (
    .base(base_q), .step(req_step), .idx(req_idx)
  );

  cwf_wrap_idx #(.OFF_W(OFF_W)) u_beat_idx (
    .base(base_q), .step(beat_step), .idx(beat_idx)
  );

  cwf_fill_buf #(
    .WORD_W    (WORD_W),
    .LINE_WORDS(LINE_WORDS)
  ) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (take_miss),
    .we     (beat_fire),
    .widx   (beat_idx),
    .wdata  (mem_beat_data),
    .ridx   (cpu_rd_off),
    .rdata  (cpu_rd_data),
    .written(written)
  );

  // Handshake edges
  assign miss_ready     = idle;
  assign mem_req_valid  = req_open;
  assign mem_req_line   = line_q;
  assign mem_req_off    = req_idx;
  assign mem_beat_ready = beat_open;

  // Data array write and early release
  assign fill_we        = beat_fire;
  assign fill_line      = line_q;
  assign fill_word      = beat_idx;
  assign fill_data      = mem_beat_data;
  assign cpu_data_valid = beat_fire && (beat_idx == crit_q);
  assign cpu_data       = mem_beat_data;
  assign line_valid     = seal;

  // Probes of the line in flight
  assign probe_match  = filling && cpu_rd_valid && (cpu_rd_line == line_q);
  assign cpu_rd_hit   = probe_match && written[cpu_rd_off];
  assign cpu_rd_stall = probe_match && !written[cpu_rd_off];
endmodule

// File: rtl/cwf_refill_checker.sv
module cwf_refill_checker #(
  parameter int LINE_A_W   = 27,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                miss_valid,
  input logic                miss_ready,
  input logic                mem_req_valid,
  input logic                mem_req_ready,
  input logic [LINE_A_W-1:0] mem_req_line,
  input logic [OFF_W-1:0]    mem_req_off,
  input logic                fill_we,
  input logic                cpu_data_valid,
  input logic                line_valid,
  input logic                cpu_rd_hit,
  input logic                cpu_rd_stall
);
  logic [7:0] wr_cnt, rel_cnt, req_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || (miss_valid && miss_ready)) begin
      wr_cnt  <= '0;
      rel_cnt <= '0;
      req_cnt <= '0;
    end else begin
      if (fill_we)                        wr_cnt  <= wr_cnt + 1'b1;
      if (cpu_data_valid)                 rel_cnt <= rel_cnt + 1'b1;
      if (mem_req_valid && mem_req_ready) req_cnt <= req_cnt + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> (!fill_we && !mem_req_valid && !line_valid));

  p_one_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (rel_cnt == 8'd1));

  p_full_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (wr_cnt == 8'(LINE_WORDS)));

  p_seal_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_valid) |-> $past(fill_we));

  p_miss_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we || line_valid) |-> !miss_ready);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_off) && $stable(mem_req_line)));

  p_req_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (req_cnt == 8'(LINE_WORDS)));

  p_probe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd_hit && cpu_rd_stall));
endmodule

bind cwf_refill_ctrl cwf_refill_checker #(
  .LINE_A_W  (LINE_A_W),
  .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_line  (mem_req_line),
  .mem_req_off   (mem_req_off),
  .fill_we       (fill_we),
  .cpu_data_valid(cpu_data_valid),
  .line_valid    (line_valid),
  .cpu_rd_hit    (cpu_rd_hit),
  .cpu_rd_stall  (cpu_rd_stall)
);

// File: tb/cwf_refill_ctrl_bench.sv
`timescale 1ns/1ps
module cwf_refill_ctrl_bench;
  localparam int AW = 27;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          order_crit = 1'b1;
  logic          miss_valid = 1'b0;
  logic          miss_ready;
  logic [AW-1:0] miss_line = '0;
  logic [2:0]    miss_off = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_line;
  logic [2:0]    mem_req_off;
  logic          mem_beat_valid = 1'b0;
  logic          mem_beat_ready;
  logic [WW-1:0] mem_beat_data = '0;
  logic          fill_we;
  logic [AW-1:0] fill_line;
  logic [2:0]    fill_word;
  logic [WW-1:0] fill_data;
  logic          line_valid;
  logic          cpu_data_valid;
  logic [WW-1:0] cpu_data;
  logic          cpu_rd_valid = 1'b0;
  logic [AW-1:0] cpu_rd_line = '0;
  logic [2:0]    cpu_rd_off = '0;
  logic          cpu_rd_hit, cpu_rd_stall;
  logic [WW-1:0] cpu_rd_data;

  cwf_refill_ctrl u_cwf_refill_ctrl (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [WW-1:0] word_of(input logic [AW-1:0] l, input logic [2:0] o);
    return {l[23:0], 5'b0, o} ^ 32'h5A00_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory responder: in-order FIFO of requested offsets
  bit        stall_en = 0, gap_en = 0;
  logic [2:0] q [16];
  logic [3:0] wp = 0, rp = 0;
  int         cnt = 0;
  logic [AW-1:0] mline = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      wp = 0; rp = 0; cnt = 0;
      mem_beat_valid <= 1'b0;
      mem_req_ready  <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        q[wp] = mem_req_off; mline = mem_req_line; wp = wp + 1; cnt = cnt + 1;
      end
      if (mem_beat_valid && mem_beat_ready) begin
        rp = rp + 1; cnt = cnt - 1;
      end
      mem_beat_valid <= (cnt != 0) && (!gap_en || cyc[0]);
      mem_beat_data  <= word_of(mline, q[rp]);
      mem_req_ready  <= !stall_en || cyc[1];
    end
  end

  // Monitor logs, sampled at the falling edge
  logic [2:0]    req_log [32];
  logic [2:0]    wr_off  [32];
  logic [WW-1:0] wr_dat  [32];
  logic [AW-1:0] wr_lin  [32];
  int            wr_cyc  [32];
  int            lv_cyc  [4];
  int            acc_cyc [4];
  int req_n = 0, wr_n = 0, rel_n = 0, lv_n = 0, acc_n = 0, busy_open = 0;
  int rel_cyc = 0;
  logic [WW-1:0] rel_dat = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready && req_n < 32) begin req_log[req_n] = mem_req_off; req_n++; end
      if (fill_we && wr_n < 32) begin
        wr_off[wr_n] = fill_word; wr_dat[wr_n] = fill_data;
        wr_lin[wr_n] = fill_line; wr_cyc[wr_n] = cyc; wr_n++;
      end
      if (cpu_data_valid) begin rel_n++; rel_cyc = cyc; rel_dat = cpu_data; end
      if (line_valid && lv_n < 4) begin lv_cyc[lv_n] = cyc; lv_n++; end
      if (miss_valid && miss_ready && acc_n < 4) begin acc_cyc[acc_n] = cyc; acc_n++; end
      if ((fill_we || line_valid) && miss_ready) busy_open++;
    end
  end

  task automatic clear_logs();
    req_n = 0; wr_n = 0; rel_n = 0; lv_n = 0; acc_n = 0; busy_open = 0;
  endtask

  task automatic send_miss(input logic [AW-1:0] l, input logic [2:0] o, input bit crit);
    @(negedge clk);
    miss_line = l; miss_off = o; order_crit = crit; miss_valid = 1'b1;
    while (!miss_ready) @(negedge clk);
    @(posedge clk); #1;
    miss_valid = 1'b0;
  endtask

  task automatic wait_seal(input int n);
    for (int i = 0; i < 500 && lv_n < n; i++) @(negedge clk);
  endtask

  task automatic run_refill(input logic [AW-1:0] l, input logic [2:0] o, input bit crit,
                            input bit stall, input bit gap, input bit flip);
    logic [2:0] e;
    int rel_at;
    clear_logs();
    stall_en = stall; gap_en = gap;
    send_miss(l, o, crit);
    if (flip) order_crit = !crit;   // R10: late change must be ignored
    wait_seal(1);
    @(negedge clk);
    chk(req_n == 8, "R8", "request count", req_n, 8);
    chk(wr_n == 8, "R5", "write count", wr_n, 8);
    for (int k = 0; k < 8 && k < req_n && k < wr_n; k++) begin
      e = crit ? 3'(o + k) : 3'(k);
      chk(req_log[k] == e, crit ? (flip ? "R10" : "R2") : "R3", "request offset", req_log[k], e);
      chk(wr_off[k] == e && wr_dat[k] == word_of(l, e) && wr_lin[k] == l, "R5",
          "fill word/data", wr_dat[k], word_of(l, e));
    end
    rel_at = crit ? 0 : int'(o);
    chk(rel_n == 1, "R4", "release count", rel_n, 1);
    chk(rel_cyc == wr_cyc[rel_at], "R4", "release cycle", rel_cyc, wr_cyc[rel_at]);
    chk(rel_dat == word_of(l, o), "R4", "release data", rel_dat, word_of(l, o));
    chk(lv_n == 1 && lv_cyc[0] == wr_cyc[7] + 1, "R6", "seal cycle", lv_cyc[0], wr_cyc[7] + 1);
    chk(busy_open == 0, "R7", "miss_ready during fill", busy_open, 0);
    stall_en = 0; gap_en = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(miss_ready && !mem_req_valid && !fill_we && !cpu_data_valid && !line_valid,
        "R1", "idle outputs after reset",
        {miss_ready, mem_req_valid, fill_we, cpu_data_valid, line_valid}, 5'b10000);
  endtask

  task automatic t_back_to_back();
    clear_logs();
    send_miss(27'h0123, 3'd2, 1'b1);
    @(negedge clk);
    miss_line = 27'h0456; miss_off = 3'd6; order_crit = 1'b1; miss_valid = 1'b1;
    for (int i = 0; i < 500 && acc_n < 2; i++) @(negedge clk);
    @(posedge clk); #1;
    miss_valid = 1'b0;
    chk(acc_n == 2 && acc_cyc[1] == lv_cyc[0] + 1, "R7", "second miss accept cycle",
        acc_cyc[1], lv_cyc[0] + 1);
    wait_seal(2);
    chk(wr_n == 16 && wr_lin[8] == 27'h0456 && wr_off[8] == 3'd6, "R7",
        "second refill first write", wr_off[8], 3'd6);
  endtask

  task automatic t_probe();
    logic [AW-1:0] l = 27'h7A5C;
    clear_logs();
    gap_en = 1;
    send_miss(l, 3'd5, 1'b1);
    for (int i = 0; i < 500 && rel_n == 0; i++) @(negedge clk);
    @(negedge clk);
    cpu_rd_valid = 1'b1; cpu_rd_line = l; cpu_rd_off = 3'd5; #1;
    chk(cpu_rd_hit && !cpu_rd_stall && cpu_rd_data == word_of(l, 3'd5), "R9",
        "probe written word", cpu_rd_data, word_of(l, 3'd5));
    cpu_rd_off = 3'd4; #1;
    chk(!cpu_rd_hit && cpu_rd_stall, "R9", "probe unwritten word",
        {cpu_rd_hit, cpu_rd_stall}, 2'b01);
    cpu_rd_line = l + 1; cpu_rd_off = 3'd5; #1;
    chk(!cpu_rd_hit && !cpu_rd_stall, "R9", "probe other line",
        {cpu_rd_hit, cpu_rd_stall}, 2'b00);
    cpu_rd_valid = 1'b0;
    wait_seal(1);
    gap_en = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();                                        // R1
    run_refill(27'h00A1, 3'd5, 1'b1, 0, 0, 0);        // R2 wrap from 5
    run_refill(27'h00B2, 3'd0, 1'b1, 0, 0, 0);        // R2 offset 0
    run_refill(27'h00C3, 3'd7, 1'b1, 1, 1, 0);        // R2 R8 wrap + back-pressure
    run_refill(27'h00D4, 3'd5, 1'b0, 0, 1, 0);        // R3 natural, mid-line release
    run_refill(27'h00E5, 3'd0, 1'b0, 1, 0, 0);        // R3 natural from 0
    run_refill(27'h00F6, 3'd3, 1'b1, 0, 0, 1);        // R10 flip to natural
    run_refill(27'h0107, 3'd6, 1'b0, 1, 1, 1);        // R10 flip to wrap
    t_back_to_back();                                 // R7
    t_probe();                                        // R9
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule